// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit processor core. The caller presents the current accumulator value, a second operand, the incoming carry, auxiliary-carry and overflow flags, and a 4-bit operation code. One clock later the block returns the new accumulator value together with the updated flag set. It also returns a parity bit that always describes the value on the result port.

The operations are binary add (with or without the incoming carry), subtract with borrow, increment, decrement, bitwise AND, OR and XOR, clear, complement, four rotations, a nibble exchange, and a BCD correction step that follows a packed-decimal addition. Flags that an operation does not define are returned exactly as they came in. The caller can therefore write the flag outputs back to its status register every time without keeping any per-operation exceptions. Operand fetch, writeback, multiply and divide stay outside the block.

Top module: `acc_alu`

## Requirements
- R1: An operation is taken when `op_valid` is 1 at a rising clock edge. Its result and flags show on the outputs after that edge, and `res_valid` is 1 for that cycle. While `op_valid` is 0, `res_valid` drops to 0 after the next edge and every other output keeps its value.
- R2: A clock edge with `rst_n` low clears every output to 0, whether or not `op_valid` is high.
- R3: Operation codes and their results: 0 add, 1 add with carry, 2 subtract with borrow, 3 A+1, 4 A−1, 5 A AND B, 6 A OR B, 7 A XOR B, 8 clear (00h), 9 complement (NOT A), 10 rotate left, 11 rotate right, 12 rotate left through carry, 13 rotate right through carry, 14 exchange nibbles (A[3:0] to the upper half, A[7:4] to the lower half), 15 decimal adjust. Plain rotations move bit 7 into bit 0 (left) or bit 0 into bit 7 (right). For one-operand codes B is ignored. The add code (0) ignores the carry input.
- R4: Add computes A+B and add-with-carry computes A+B+CY, modulo 256. CY out is the carry out of bit 7. AC out is the carry from bit 3 into bit 4.
- R5: For the three arithmetic codes (0, 1 and 2), OV out is 1 when exactly one of two events happens: a carry (or borrow) out of bit 6, or a carry (or borrow) out of bit 7.
- R6: Subtract with borrow computes A−B−CY modulo 256. CY out is the borrow out of bit 7. AC out is the borrow taken from bit 4 into the lower nibble.
- R7: Increment, decrement, AND, OR, XOR, clear, complement, plain rotates and nibble exchange return CY, AC and OV equal to their inputs. Decimal adjust returns AC and OV equal to their inputs. The rotates through carry (R8) return AC and OV equal to their inputs.
- R8: Rotate left through carry gives {A[6:0], CY} with CY out = A[7]. Rotate right through carry gives {CY, A[7:1]} with CY out = A[0].
- R9: Decimal adjust works in two steps. Step 1 adds 06h when A[3:0] > 9 or AC = 1. Step 2 adds 60h to that intermediate when its upper nibble is > 9, or CY = 1, or step 1 carried out of bit 7. CY out is 1 if CY in was 1 or either step carried out of bit 7; otherwise it is 0.
- R10: `par_out` is 1 exactly when `res_out` holds an odd number of ones, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Operation is applied at this edge |
| op_code | input | 4 | Operation select (see R3) |
| acc_in | input | 8 | Accumulator value A |
| opnd_in | input | 8 | Second operand B |
| cy_in | input | 1 | Incoming carry flag |
| ac_in | input | 1 | Incoming auxiliary-carry flag |
| ov_in | input | 1 | Incoming overflow flag |
| res_valid | output | 1 | Outputs hold a newly applied operation |
| res_out | output | 8 | New accumulator value |
| cy_out | output | 1 | Carry flag out |
| ac_out | output | 1 | Auxiliary-carry flag out |
| ov_out | output | 1 | Overflow flag out |
| par_out | output | 1 | Odd-parity indicator of res_out |

## Verification
The only state is the single output register. A fault in the arithmetic or selection logic therefore reaches the ports exactly one edge after the operation is applied, and never later. A wrong carry chain tap shows as a bad CY, AC or OV on the boundary operands: 7Fh+01h, 80h−01h, 7Fh−FFh and FFh+01h. A lost hold shows as outputs that change while `op_valid` is low. The decimal-adjust checks cover each step on its own, both steps together, and the case where the carry comes in from outside. A mis-steered flag passthrough shows as an input flag that fails to come back on a logical or rotate code.

// File: rtl/acc_alu_pkg.sv
// Package acc_alu_pkg
// Shared widths, the operation encoding and the result bundle used by the
// accumulator ALU. Assumes an even data width so that it splits into two nibbles.
package acc_alu_pkg;

    localparam int DW  = 8;
    localparam int NIB = DW / 2;
    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUBB = 4'd2,
        OP_INC  = 4'd3,
        OP_DEC  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_CLR  = 4'd8,
        OP_CPL  = 4'd9,
        OP_RL   = 4'd10,
        OP_RR   = 4'd11,
        OP_RLC  = 4'd12,
        OP_RRC  = 4'd13,
        OP_SWAP = 4'd14,
        OP_DA   = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          cy;
        logic          ac;
        logic          ov;
    } alu_res_t;

endpackage

// File: rtl/acc_alu_arith.sv
// Module acc_alu_arith
// Adder/subtractor with status flags. Subtraction is done as A + ~B + ~borrow;
// the carries are then inverted back into borrows. Three carry taps are taken
// from three separate sums: out of the low nibble, out of bit DW-2 and out of
// bit DW-1. Purely combinational.
module acc_alu_arith
    import acc_alu_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cy_i,
    input  logic          sub_i,
    input  logic          use_cy_i,
    output logic [DW-1:0] res_o,
    output logic          cy_o,
    output logic          ac_o,
    output logic          ov_o
);

    logic [DW-1:0] b_eff;
    logic          c_eff;
    logic          cin;
    logic [NIB:0]  sum_lo;
    logic [DW-1:0] sum_low7;
    logic [DW:0]   sum_full;

    // Condition the operand and the carry-in for add or subtract.
    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        c_eff = use_cy_i & cy_i;
        cin   = sub_i ? ~c_eff : c_eff;
    end

    // Three sums of increasing width give the three carry taps.
    always_comb begin
        sum_lo   = {1'b0, a_i[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + (NIB+1)'(cin);
        sum_low7 = {1'b0, a_i[DW-2:0]}  + {1'b0, b_eff[DW-2:0]}  + DW'(cin);
        sum_full = {1'b0, a_i}          + {1'b0, b_eff}          + (DW+1)'(cin);
    end

    // Turn the carries into flags; on subtract they are borrows.
    always_comb begin
        res_o = sum_full[DW-1:0];
        cy_o  = sum_full[DW] ^ sub_i;
        ac_o  = sum_lo[NIB]  ^ sub_i;
        ov_o  = sum_low7[DW-1] ^ sum_full[DW];
    end

endmodule

// File: rtl/acc_alu_unary.sv
// Module acc_alu_unary
// Logical operations, increment/decrement, clear, complement, the four
// rotations and the nibble exchange. Only the rotates through carry change
// the carry; for every other code here the carry passes straight through.
// Purely combinational; codes outside this group return A unchanged.
module acc_alu_unary
    import acc_alu_pkg::*;
(
    input  alu_op_e       op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cy_i,
    output logic [DW-1:0] res_o,
    output logic          cy_o
);

    logic [DW-1:0] swapped;

    // Nibble exchange wiring, one pair of bits per step.
    for (genvar g = 0; g < NIB; g++) begin : g_swap
        assign swapped[g]       = a_i[g+NIB];
        assign swapped[g+NIB]   = a_i[g];
    end

    // Pick the result and the carry for the selected code.
    always_comb begin
        res_o = a_i;
        cy_o  = cy_i;
        case (op_i)
            OP_INC:  res_o = a_i + DW'(1);
            OP_DEC:  res_o = a_i - DW'(1);
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_CLR:  res_o = '0;
            OP_CPL:  res_o = ~a_i;
            OP_RL:   res_o = {a_i[DW-2:0], a_i[DW-1]};
            OP_RR:   res_o = {a_i[0], a_i[DW-1:1]};
            OP_RLC: begin
                res_o = {a_i[DW-2:0], cy_i};
                cy_o  = a_i[DW-1];
            end
            OP_RRC: begin
                res_o = {cy_i, a_i[DW-1:1]};
                cy_o  = a_i[0];
            end
            OP_SWAP: res_o = swapped;
            default: res_o = a_i;
        endcase
    end

endmodule

// File: rtl/acc_alu_decadj.sv
// Module acc_alu_decadj
// BCD correction after a packed-decimal addition. It runs in two steps: a low
// correction of 06h, then a high correction of 60h decided on the intermediate
// value. The carry out is sticky: it is set if it came in set or if either
// step carried. Purely combinational.
module acc_alu_decadj
    import acc_alu_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  logic          cy_i,
    input  logic          ac_i,
    output logic [DW-1:0] res_o,
    output logic          cy_o
);

    localparam logic [DW:0]  ADJ_LO  = (DW+1)'(6);
    localparam logic [DW:0]  ADJ_HI  = ADJ_LO << NIB;
    localparam logic [NIB-1:0] DIGIT_MAX = NIB'(9);

    logic          fix_lo;
    logic          fix_hi;
    logic [DW:0]   step1;
    logic [DW:0]   step2;

    // Step 1: correct the low digit.
    always_comb begin
        fix_lo = (a_i[NIB-1:0] > DIGIT_MAX) | ac_i;
        step1  = {1'b0, a_i} + (fix_lo ? ADJ_LO : '0);
    end

    // Step 2: correct the high digit of the intermediate value.
    always_comb begin
        fix_hi = (step1[DW-1:NIB] > DIGIT_MAX) | cy_i | step1[DW];
        step2  = {1'b0, step1[DW-1:0]} + (fix_hi ? ADJ_HI : '0);
    end

    // Final value and sticky carry.
    always_comb begin
        res_o = step2[DW-1:0];
        cy_o  = cy_i | step1[DW] | step2[DW];
    end

endmodule

// File: rtl/acc_alu.sv
// Module acc_alu
// Top of the accumulator ALU. It selects among the arithmetic, unary and
// decimal-adjust units by operation code and registers the result, the flags
// and the result parity. The register loads only when op_valid is high, so the
// outputs hold between operations. Assumes op_code and the operands are stable
// around the rising edge. Synchronous active-low reset.
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           op_valid,
    input  logic [OPW-1:0] op_code,
    input  logic [DW-1:0]  acc_in,
    input  logic [DW-1:0]  opnd_in,
    input  logic           cy_in,
    input  logic           ac_in,
    input  logic           ov_in,
    output logic           res_valid,
    output logic [DW-1:0]  res_out,
    output logic           cy_out,
    output logic           ac_out,
    output logic           ov_out,
    output logic           par_out
);

    alu_op_e       op;
    logic          is_sub;
    logic          with_cy;
    logic [DW-1:0] ar_res;
    logic          ar_cy, ar_ac, ar_ov;
    logic [DW-1:0] un_res;
    logic          un_cy;
    logic [DW-1:0] da_res;
    logic          da_cy;
    alu_res_t      nxt;

    // Decode the raw code into the enum and the adder controls.
    always_comb begin
        op      = alu_op_e'(op_code);
        is_sub  = (op == OP_SUBB);
        with_cy = (op != OP_ADD);
    end

    acc_alu_arith u_arith (
        .a_i      (acc_in),
        .b_i      (opnd_in),
        .cy_i     (cy_in),
        .sub_i    (is_sub),
        .use_cy_i (with_cy),
        .res_o    (ar_res),
        .cy_o     (ar_cy),
        .ac_o     (ar_ac),
        .ov_o     (ar_ov)
    );

    acc_alu_unary u_unary (
        .op_i  (op),
        .a_i   (acc_in),
        .b_i   (opnd_in),
        .cy_i  (cy_in),
        .res_o (un_res),
        .cy_o  (un_cy)
    );

    acc_alu_decadj u_decadj (
        .a_i   (acc_in),
        .cy_i  (cy_in),
        .ac_i  (ac_in),
        .res_o (da_res),
        .cy_o  (da_cy)
    );

    // Steer the selected unit's result and flags into the register input.
    always_comb begin
        case (op)
            OP_ADD, OP_ADDC, OP_SUBB: nxt = '{res: ar_res, cy: ar_cy, ac: ar_ac, ov: ar_ov};
            OP_DA:                    nxt = '{res: da_res, cy: da_cy, ac: ac_in, ov: ov_in};
            default:                  nxt = '{res: un_res, cy: un_cy, ac: ac_in, ov: ov_in};
        endcase
    end

    // Output register: load on a valid operation, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_out   <= '0;
            cy_out    <= 1'b0;
            ac_out    <= 1'b0;
            ov_out    <= 1'b0;
            par_out   <= 1'b0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                res_out <= nxt.res;
                cy_out  <= nxt.cy;
                ac_out  <= nxt.ac;
                ov_out  <= nxt.ov;
                par_out <= ^nxt.res;
            end
        end
    end

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    // R1
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && $stable(res_out) && $stable(cy_out)
                       && $stable(ac_out) && $stable(ov_out)));

    // R10
    parity_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_out == ^res_out);

    // R7
    flags_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code inside {4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8,
                                      4'd9, 4'd10, 4'd11, 4'd14}))
        |=> (cy_out == $past(cy_in) && ac_out == $past(ac_in)
             && ov_out == $past(ov_in)));

    // R8
    rlc_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd12) |=> (cy_out == $past(acc_in[DW-1])
                                             && res_out[0] == $past(cy_in)));

    // R3
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd8) |=> (res_out == '0));

    // R9
    da_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd15 && cy_in) |=> cy_out);

endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 27;

    // {op, A, B, cy_in, ac_in, ov_in, exp_res, exp_cy, exp_ac, exp_ov}
    localparam logic [33:0] VEC [NV] = '{
        {4'd0,  8'h3A, 8'h26, 3'b100, 8'h60, 3'b010},
        {4'd0,  8'h7F, 8'h01, 3'b000, 8'h80, 3'b011},
        {4'd0,  8'hFF, 8'h01, 3'b000, 8'h00, 3'b110},
        {4'd0,  8'h80, 8'h80, 3'b000, 8'h00, 3'b101},
        {4'd1,  8'h0F, 8'h00, 3'b100, 8'h10, 3'b010},
        {4'd1,  8'hFE, 8'h01, 3'b100, 8'h00, 3'b110},
        {4'd2,  8'h50, 8'h20, 3'b000, 8'h30, 3'b000},
        {4'd2,  8'h10, 8'h01, 3'b000, 8'h0F, 3'b010},
        {4'd2,  8'h00, 8'h00, 3'b100, 8'hFF, 3'b110},
        {4'd2,  8'h80, 8'h01, 3'b000, 8'h7F, 3'b011},
        {4'd2,  8'h7F, 8'hFF, 3'b000, 8'h80, 3'b101},
        {4'd3,  8'hFF, 8'hEE, 3'b101, 8'h00, 3'b101},
        {4'd4,  8'h00, 8'hEE, 3'b010, 8'hFF, 3'b010},
        {4'd5,  8'hF0, 8'h3C, 3'b111, 8'h30, 3'b111},
        {4'd6,  8'hA0, 8'h05, 3'b000, 8'hA5, 3'b000},
        {4'd7,  8'hFF, 8'h0F, 3'b100, 8'hF0, 3'b100},
        {4'd8,  8'h5A, 8'hEE, 3'b011, 8'h00, 3'b011},
        {4'd9,  8'h5A, 8'hEE, 3'b100, 8'hA5, 3'b100},
        {4'd10, 8'h81, 8'hEE, 3'b000, 8'h03, 3'b000},
        {4'd11, 8'h81, 8'hEE, 3'b110, 8'hC0, 3'b110},
        {4'd12, 8'h81, 8'hEE, 3'b011, 8'h02, 3'b111},
        {4'd13, 8'h02, 8'hEE, 3'b100, 8'h81, 3'b000},
        {4'd14, 8'h3C, 8'hEE, 3'b001, 8'hC3, 3'b001},
        {4'd15, 8'h81, 8'hEE, 3'b010, 8'h87, 3'b010},
        {4'd15, 8'h9A, 8'hEE, 3'b000, 8'h00, 3'b100},
        {4'd15, 8'h12, 8'hEE, 3'b100, 8'h72, 3'b100},
        {4'd15, 8'h25, 8'hEE, 3'b000, 8'h25, 3'b000}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = '0;
    logic [7:0] acc_in = '0;
    logic [7:0] opnd_in = '0;
    logic       cy_in = 1'b0, ac_in = 1'b0, ov_in = 1'b0;
    logic       res_valid;
    logic [7:0] res_out;
    logic       cy_out, ac_out, ov_out, par_out;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_alu u_acc_alu (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .acc_in(acc_in), .opnd_in(opnd_in), .cy_in(cy_in), .ac_in(ac_in),
        .ov_in(ov_in), .res_valid(res_valid), .res_out(res_out),
        .cy_out(cy_out), .ac_out(ac_out), .ov_out(ov_out), .par_out(par_out)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string res_tag(input logic [3:0] op);
        case (op)
            4'd0, 4'd1: return "R4";
            4'd2:       return "R6";
            4'd12, 4'd13: return "R8";
            4'd15:      return "R9";
            default:    return "R3";
        endcase
    endfunction

    function automatic string flag_tag(input logic [3:0] op);
        case (op)
            4'd0, 4'd1: return "R4";
            4'd2:       return "R6";
            4'd12, 4'd13: return "R8";
            4'd15:      return "R9";
            default:    return "R7";
        endcase
    endfunction

    task automatic all_zero(input string req);
        chk(req, "res_valid", 32'(res_valid), 0);
        chk(req, "res_out", 32'(res_out), 0);
        chk(req, "flags", 32'({cy_out, ac_out, ov_out}), 0);
        chk(req, "par_out", 32'(par_out), 0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] held_res;
        logic [3:0] held_flags;

        // R2: reset state
        repeat (3) @(negedge clk);
        all_zero("R2");
        rst_n = 1'b1;

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {op_code, acc_in, opnd_in, cy_in, ac_in, ov_in} = VEC[i][33:11];
            op_valid = 1'b1;
            @(negedge clk);
            chk("R1", "res_valid", 32'(res_valid), 1);
            chk(res_tag(VEC[i][33:30]), "res_out", 32'(res_out), 32'(VEC[i][10:3]));
            chk(flag_tag(VEC[i][33:30]), "cy_out", 32'(cy_out), 32'(VEC[i][2]));
            chk(flag_tag(VEC[i][33:30]), "ac_out", 32'(ac_out), 32'(VEC[i][1]));
            if (VEC[i][33:30] <= 4'd2)
                chk("R5", "ov_out", 32'(ov_out), 32'(VEC[i][0]));
            else
                chk("R7", "ov_out", 32'(ov_out), 32'(VEC[i][0]));
            chk("R10", "par_out", 32'(par_out), 32'(^VEC[i][10:3]));
        end

        // R1: hold while op_valid is low and inputs change
        held_res   = res_out;
        held_flags = {cy_out, ac_out, ov_out, par_out};
        op_valid = 1'b0;
        op_code  = 4'd0;
        acc_in   = 8'h11;
        opnd_in  = 8'h22;
        cy_in    = 1'b1;
        ac_in    = 1'b1;
        ov_in    = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "idle res_valid", 32'(res_valid), 0);
        chk("R1", "idle res_out", 32'(res_out), 32'(held_res));
        chk("R1", "idle flags", 32'({cy_out, ac_out, ov_out, par_out}), 32'(held_flags));

        // R3: add ignores the carry input (A=01h, B=01h, cy=1 -> 02h)
        op_valid = 1'b1;
        op_code  = 4'd0;
        acc_in   = 8'h01;
        opnd_in  = 8'h01;
        cy_in    = 1'b1;
        ac_in    = 1'b0;
        ov_in    = 1'b0;
        @(negedge clk);
        chk("R3", "add ignores cy", 32'(res_out), 32'h02);
        chk("R4", "add cy_out", 32'(cy_out), 0);

        // R10: parity of an odd result (07h) after an add
        acc_in  = 8'h03;
        opnd_in = 8'h04;
        @(negedge clk);
        chk("R10", "odd parity", 32'(par_out), 1);

        // R2: reset overrides a valid operation
        rst_n = 1'b0;
        @(negedge clk);
        all_zero("R2");
        rst_n = 1'b1;
        op_valid = 1'b0;
        @(negedge clk);
        chk("R1", "after reset idle", 32'(res_valid), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule